// File: doc/BRIEF.md
# Command/Data Display Bus Master

This block is the write and read engine for a small display module that keeps its own frame memory and controller. A host hands it one request at a time over a valid/ready handshake: a 16-bit word, a flag that marks it as a command or as display data, and a flag that asks for a read instead of a write. The block turns each request into one or two timed transfers on a parallel bus and then returns to idle. It never refreshes the panel on its own; the bus is quiet unless a request arrives.

Two strobe protocols share one sequencer, picked by a static mode input. In strobe-pair mode a write pulses an active-low write strobe and a read pulses a separate active-low read strobe. In enable mode a direction level (high for read, low for write) is held through the transfer and an active-high enable pulses. The bus carries 8 or 16 significant bits, picked by a static width input. In 8-bit mode a display-data write is split into two transfers, upper byte first. Setup, strobe-active and hold lengths are given in clock cycles. The data bus is driven as separate out, in and output-enable signals so that the pad ring can build the tristate driver.

Top module: `dbus_master`

## Requirements
- R1: After reset and whenever no transfer is running, `req_ready` is 1, `bus_wr_n` and `bus_rd_n` are 1, `bus_en` is 0, `bus_rw` is 1 and `bus_oe` is 0.
- R2: With `cfg_mode` = 0 (strobe-pair), a write pulses only `bus_wr_n` low and a read pulses only `bus_rd_n` low; `bus_rw` stays 1 and `bus_en` stays 0 throughout.
- R3: With `cfg_mode` = 1 (enable), `bus_rw` is 0 for a write and 1 for a read from the first setup cycle to the last hold cycle, `bus_en` is high only in the strobe-active cycles, and `bus_wr_n` and `bus_rd_n` stay 1.
- R4: `bus_dc` is 0 for a command and 1 for display data, and holds that level from the first setup cycle to the last hold cycle of the request.
- R5: Each transfer has a setup phase of `cfg_setup` cycles, a strobe-active phase of `cfg_active` cycles and a hold phase of `cfg_hold` cycles, in that order; a programmed 0 counts as 1 cycle.
- R6: For a write, `bus_oe` is 1 from the first setup cycle to the last hold cycle and `bus_dout` does not change while the strobe is active.
- R7: For a read, `bus_oe` stays 0; `bus_din` is captured at the clock edge that ends the last strobe-active cycle, and `rsp_valid` is 1 for exactly one cycle, the first hold cycle, with the captured value on `rsp_word`.
- R8: With `cfg_bus8` = 0, every request is one transfer that carries the full 16-bit word on `bus_dout`, and a read returns all 16 bits of `bus_din`.
- R9: With `cfg_bus8` = 1, a display-data write is two transfers: the first drives `req_word[15:8]` and the second `req_word[7:0]` on `bus_dout[7:0]`, with `bus_dout[15:8]` = 0; between the two strobes lie hold plus setup cycles.
- R10: With `cfg_bus8` = 1, a command write is one transfer of `req_word[7:0]`, and a read is one transfer whose result is `bus_din[7:0]` with the upper 8 bits 0.
- R11: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` is then 0 until the last hold cycle of the last transfer has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 1 | 0 = strobe-pair protocol, 1 = enable protocol (static) |
| cfg_bus8 | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus (static) |
| cfg_setup | input | 4 | Setup length in cycles (0 acts as 1) |
| cfg_active | input | 4 | Strobe-active length in cycles (0 acts as 1) |
| cfg_hold | input | 4 | Hold length in cycles (0 acts as 1) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 1 | 1 = command, 0 = display data |
| req_read | input | 1 | 1 = read, 0 = write |
| req_word | input | 16 | Word to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_word | output | 16 | Read result |
| bus_dc | output | 1 | Data/command line, 0 = command |
| bus_wr_n | output | 1 | Write strobe, strobe-pair mode |
| bus_rd_n | output | 1 | Read strobe, strobe-pair mode |
| bus_rw | output | 1 | Direction level, enable mode |
| bus_en | output | 1 | Enable strobe, enable mode |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data bus outgoing value |
| bus_din | input | 16 | Data bus incoming value |

## Verification
The bench sweeps both protocols, both bus widths and a grid of setup, active and hold lengths that includes the zero settings, and runs a command write, a data write and a read at every point. Counting the run lengths of strobe-active and strobe-idle cycles separates a phase that is one cycle short or long, a zero that is not promoted to one, and a missing or extra second beat. The read path changes `bus_din` in every active cycle, so a capture taken one edge early or late returns a different value, and distinct upper and lower bytes in the write words expose swapped byte order or a wrong lane.

// File: rtl/dbus_pkg.sv
// Shared types for the display bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package dbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    localparam logic MODE_PAIR   = 1'b0;
    localparam logic MODE_ENABLE = 1'b1;
endpackage

// File: rtl/dbus_sequencer.sv
// Phase sequencer: walks setup, active and hold for one or two beats.
// Assumes: timing inputs stay constant while a request is in flight.
module dbus_sequencer
    import dbus_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_active,
    input  logic [TW-1:0] t_hold,
    input  logic          start,
    input  logic          two_beats,
    output phase_t        phase,
    output logic          beat,
    output logic          last_active
);
    phase_t        phase_q;
    logic [TW-1:0] cnt_q;
    logic          beat_q;
    logic          two_q;

    // Converts a programmed length into a down-counter load (0 acts as 1).
    function automatic logic [TW-1:0] load_of(input logic [TW-1:0] t);
        return (t == '0) ? '0 : t - TW'(1);
    endfunction

    // Advances the phase when the counter runs out, else counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            beat_q  <= 1'b0;
            two_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= load_of(t_setup);
                    beat_q  <= 1'b0;
                    two_q   <= two_beats;
                end
                PH_SETUP: if (cnt_q == '0) begin
                    phase_q <= PH_ACTIVE;
                    cnt_q   <= load_of(t_active);
                end else cnt_q <= cnt_q - TW'(1);
                PH_ACTIVE: if (cnt_q == '0) begin
                    phase_q <= PH_HOLD;
                    cnt_q   <= load_of(t_hold);
                end else cnt_q <= cnt_q - TW'(1);
                PH_HOLD: if (cnt_q == '0) begin
                    if (two_q && !beat_q) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= load_of(t_setup);
                        beat_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end else cnt_q <= cnt_q - TW'(1);
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase       = phase_q;
    assign beat        = beat_q;
    assign last_active = (phase_q == PH_ACTIVE) && (cnt_q == '0);
endmodule

// File: rtl/dbus_lanes.sv
// Data path: latches the request, picks the outgoing byte lane and
// captures read data. Assumes cfg_bus8 is static.
module dbus_lanes #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] req_word,
    input  logic              req_cmd,
    input  logic              req_read,
    input  logic              narrow,
    input  logic              beat,
    input  logic              capture,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] out_word,
    output logic              cur_cmd,
    output logic              cur_read,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word
);
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] word_q;
    logic              sel_hi;

    // Holds the request fields for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            cur_cmd  <= 1'b0;
            cur_read <= 1'b0;
        end else if (start) begin
            word_q   <= req_word;
            cur_cmd  <= req_cmd;
            cur_read <= req_read;
        end
    end

    // Upper byte goes first only for the first beat of a narrow data word.
    assign sel_hi = !cur_cmd && !beat;

    // Chooses the outgoing lane content for the bus width in use.
    always_comb begin
        if (narrow)
            out_word = {{BYTE_W{1'b0}}, sel_hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0]};
        else
            out_word = word_q;
    end

    // Captures read data at the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_word  <= '0;
        end else begin
            rsp_valid <= capture && cur_read;
            if (capture && cur_read)
                rsp_word <= narrow ? {{BYTE_W{1'b0}}, din[BYTE_W-1:0]} : din;
        end
    end
endmodule

// File: rtl/dbus_pins.sv
// Pin encoder: maps the sequencer phase onto either strobe protocol.
// Assumes cfg_mode is static; the unused protocol's pins sit idle.
module dbus_pins
    import dbus_pkg::*;
(
    input  phase_t phase,
    input  logic   mode,
    input  logic   cur_read,
    input  logic   cur_cmd,
    output logic   wr_n,
    output logic   rd_n,
    output logic   rw,
    output logic   en,
    output logic   oe,
    output logic   dc
);
    logic busy;
    logic act;

    assign busy = (phase != PH_IDLE);
    assign act  = (phase == PH_ACTIVE);

    // Drives the strobe pins of the selected protocol.
    always_comb begin
        wr_n = 1'b1;
        rd_n = 1'b1;
        rw   = 1'b1;
        en   = 1'b0;
        if (mode == MODE_PAIR) begin
            wr_n = !(act && !cur_read);
            rd_n = !(act && cur_read);
        end else begin
            rw = busy ? cur_read : 1'b1;
            en = act;
        end
    end

    assign oe = busy && !cur_read;
    assign dc = !cur_cmd;
endmodule

// File: rtl/dbus_master.sv
// Display bus master top: one host request port, two strobe protocols,
// 8- or 16-bit bus. Assumes static cfg_mode/cfg_bus8 and timing fields.
module dbus_master
    import dbus_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_bus8,
    input  logic [TW-1:0]     cfg_setup,
    input  logic [TW-1:0]     cfg_active,
    input  logic [TW-1:0]     cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_cmd,
    input  logic              req_read,
    input  logic [WORD_W-1:0] req_word,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic              bus_dc,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_rw,
    output logic              bus_en,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_dout,
    input  logic [WORD_W-1:0] bus_din
);
    phase_t phase;
    logic   beat;
    logic   last_active;
    logic   start;
    logic   cur_cmd;
    logic   cur_read;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    dbus_sequencer #(.TW(TW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .t_setup     (cfg_setup),
        .t_active    (cfg_active),
        .t_hold      (cfg_hold),
        .start       (start),
        .two_beats   (cfg_bus8 && !req_cmd && !req_read),
        .phase       (phase),
        .beat        (beat),
        .last_active (last_active)
    );

    dbus_lanes #(.WORD_W(WORD_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_word  (req_word),
        .req_cmd   (req_cmd),
        .req_read  (req_read),
        .narrow    (cfg_bus8),
        .beat      (beat),
        .capture   (last_active),
        .din       (bus_din),
        .out_word  (bus_dout),
        .cur_cmd   (cur_cmd),
        .cur_read  (cur_read),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word)
    );

    dbus_pins u_pins (
        .phase    (phase),
        .mode     (cfg_mode),
        .cur_read (cur_read),
        .cur_cmd  (cur_cmd),
        .wr_n     (bus_wr_n),
        .rd_n     (bus_rd_n),
        .rw       (bus_rw),
        .en       (bus_en),
        .oe       (bus_oe),
        .dc       (bus_dc)
    );
endmodule

// File: rtl/dbus_master_chk.sv
// Protocol checker for dbus_master, attached by bind below.
// Assumes the same clock and synchronous active-low reset as the top.
module dbus_master_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mode,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              bus_dc,
    input logic              bus_wr_n,
    input logic              bus_rd_n,
    input logic              bus_rw,
    input logic              bus_en,
    input logic              bus_oe,
    input logic [WORD_W-1:0] bus_dout
);
    logic strobe;
    assign strobe = cfg_mode ? bus_en : (!bus_wr_n || !bus_rd_n);

    assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));

    assert_pair_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> (bus_rw && !bus_en));

    assert_enable_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> (bus_wr_n && bus_rd_n));

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!strobe && !bus_oe));

    assert_busy_while_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !req_ready);

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cfg_mode && !bus_rd_n) || (cfg_mode && bus_en && bus_rw)) |-> !bus_oe);

    assert_stable_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> ($stable(bus_dout) && $stable(bus_dc)));

    assert_rsp_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(strobe) && !strobe));
endmodule

bind dbus_master dbus_master_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_dc    (bus_dc),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .bus_rw    (bus_rw),
    .bus_en    (bus_en),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout)
);

// File: tb/dbus_master_bench.sv
// Sweeps protocol, width and timing; checks every request at the pins.
module dbus_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        cfg_bus8 = 1'b0;
    logic [3:0]  cfg_setup = 4'd1;
    logic [3:0]  cfg_active = 4'd1;
    logic [3:0]  cfg_hold = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_cmd = 1'b0;
    logic        req_read = 1'b0;
    logic [15:0] req_word = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        bus_dc, bus_wr_n, bus_rd_n, bus_rw, bus_en, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbus_master u_dbus_master (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bus8(cfg_bus8),
        .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_hold(cfg_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_read(req_read), .req_word(req_word), .rsp_valid(rsp_valid),
        .rsp_word(rsp_word), .bus_dc(bus_dc), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_rw(bus_rw), .bus_en(bus_en),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic check_idle();
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check({bus_wr_n, bus_rd_n, bus_rw, bus_en, bus_oe} == 5'b11100,
              "R1 idle pins", int'({bus_wr_n, bus_rd_n, bus_rw, bus_en, bus_oe}), 5'b11100);
    endtask

    // One request from the host side with cycle-by-cycle pin checks.
    task automatic run_xfer(input bit cmd, input bit rd, input logic [15:0] w);
        int s = eff(int'(cfg_setup));
        int a = eff(int'(cfg_active));
        int h = eff(int'(cfg_hold));
        bit two = cfg_bus8 && !cmd && !rd;
        int runs[6];
        int ridx = 0;
        bit prev = 1'b0;
        int cyc = 0;
        int beat = 0;
        int acnt = 0;
        int rsp_seen = 0;
        logic [15:0] base = 16'h3C50 ^ w;
        logic [15:0] exp_rsp = '0;
        logic [15:0] got_rsp = '0;
        bit pin_ok = 1'b1;
        bit dc_ok = 1'b1;
        bit oe_ok = 1'b1;
        bit data_ok = 1'b1;
        logic [15:0] bad_data = '0;
        logic [15:0] exp_data = '0;
        foreach (runs[i]) runs[i] = 0;

        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_read = rd; req_word = w;
        check(req_ready == 1'b1, "R11 ready before accept", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && cyc < 200) begin
            bit act = cfg_mode ? bus_en : (rd ? !bus_rd_n : !bus_wr_n);
            if (act != prev && ridx < 5) ridx++;
            runs[ridx]++;
            // R2 / R3: protocol pin levels
            if (!cfg_mode) begin
                if (!(bus_rw && !bus_en)) pin_ok = 1'b0;
                if (rd ? !bus_wr_n : !bus_rd_n) pin_ok = 1'b0;
            end else begin
                if (!(bus_wr_n && bus_rd_n)) pin_ok = 1'b0;
                if (bus_rw != rd) pin_ok = 1'b0;
            end
            if (bus_dc != !cmd) dc_ok = 1'b0;
            if (bus_oe != !rd) oe_ok = 1'b0;
            if (act && !prev && !rd) begin
                if (!cfg_bus8) exp_data = w;
                else if (cmd) exp_data = {8'h00, w[7:0]};
                else exp_data = (beat == 0) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
                if (bus_dout != exp_data) begin data_ok = 1'b0; bad_data = bus_dout; end
                beat++;
            end
            if (act && rd) begin
                bus_din = base + 16'(acnt);
                exp_rsp = cfg_bus8 ? {8'h00, bus_din[7:0]} : bus_din;
                acnt++;
            end
            if (rsp_valid) begin
                rsp_seen++;
                got_rsp = rsp_word;
                if (act || !prev) rsp_seen += 10;
            end
            prev = act;
            cyc++;
            @(negedge clk);
        end
        if (two) begin
            check(ridx == 4 && runs[0] == s && runs[1] == a && runs[2] == h + s &&
                  runs[3] == a && runs[4] == h, "R9 R5 two-beat phase lengths",
                  runs[2], h + s);
        end else begin
            check(ridx == 2 && runs[0] == s && runs[1] == a && runs[2] == h,
                  "R5 phase lengths", runs[0] * 256 + runs[1] * 16 + runs[2], s * 256 + a * 16 + h);
        end
        check(cyc == (two ? 2 : 1) * (s + a + h), "R11 ready low span", cyc, (two ? 2 : 1) * (s + a + h));
        check(pin_ok, cfg_mode ? "R3 enable pins" : "R2 strobe-pair pins", int'(pin_ok), 1);
        check(dc_ok, "R4 data/command level", int'(bus_dc), int'(!cmd));
        check(oe_ok, rd ? "R7 bus released" : "R6 bus driven", int'(bus_oe), int'(!rd));
        if (!rd) begin
            check(data_ok, cfg_bus8 ? (cmd ? "R10 command byte" : "R9 byte order") : "R8 full word",
                  int'(bad_data), int'(exp_data));
            check(beat == (two ? 2 : 1), "R9 R10 beat count", beat, two ? 2 : 1);
        end else begin
            check(rsp_seen == 1 && got_rsp == exp_rsp,
                  cfg_bus8 ? "R7 R10 narrow read capture" : "R7 R8 read capture",
                  int'(got_rsp) + rsp_seen * 65536, int'(exp_rsp) + 65536);
        end
        check_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle();
        rst_n = 1'b1;
        @(negedge clk);
        check_idle();
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 3; s += 2) begin
                    for (int a = 0; a < 4; a++) begin
                        for (int h = 0; h < 4; h += 1) begin
                            cfg_mode = m[0]; cfg_bus8 = b[0];
                            cfg_setup = 4'(s); cfg_active = 4'(a); cfg_hold = 4'(h);
                            run_xfer(1'b1, 1'b0, 16'h9A00 + 16'(a * 16 + h));
                            run_xfer(1'b0, 1'b0, 16'hC3 + 16'(s * 4096 + a * 256));
                            run_xfer(1'b0, 1'b1, 16'h1234 + 16'(h * 17));
                        end
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule